// File: doc/BRIEF.md
# Serial Slave-Mode FPGA Bitstream Loader

This block configures a downstream FPGA over its bit-serial slave interface. When it gets a start pulse, it switches on the target's power and waits a settle time. It then pulses the target's active-low program line and waits for the target's init line to rise. After that it shifts every byte of the image out one bit at a time, with each bit placed on the data line before a rising edge of the configuration clock. Once the last byte has gone out, it keeps toggling the clock until the target raises its done line.

The image comes in as a byte stream with a valid/ready handshake. A length input gives the total number of bytes. An optional swap mode reverses the byte order inside each group of four, so a stream stored as little-endian 32-bit words still reaches the target in the order it expects. Each wait and each poll limit is counted in system clocks and set by a parameter. A run-time input sets the half-period of the configuration clock.

Top module: `slave_serial_loader`

## Requirements
- R1: After reset: `busy`, `done`, `error`, `powerEn`, `cclk`, `din` and `inReady` are 0, and `progB` is 1.
- R2: An accepted start sets `powerEn` to 1, and it stays 1. `busy` is held for exactly SETTLE_CYCLES clocks before `progB` falls. While `powerEn` is 0, `cclk` stays 0 and `progB` stays 1.
- R3: `progB` is driven low for exactly PROG_LOW_CYCLES clocks, then driven high. While the block is not busy, `progB` is always high.
- R4: After `progB` is released, `initB` is polled once per clock. If `initB` is still low after INIT_POLL_LIMIT polls, the run ends with `error`=1, `busy`=0 and no `cclk` edge.
- R5: Every byte goes out most significant bit first. `din` holds the bit at each rising edge of `cclk` and does not change while `cclk` is high. `cclk` is low whenever `inReady` is 1.
- R6: Each high phase of `cclk` lasts exactly `halfPeriod` clocks, and each low phase lasts at least that long. A value of 0 is treated as 1.
- R7: With `swapEn`=1, stream byte k is sent in position k XOR 3. The sent order is therefore 3,2,1,0,7,6,5,4,…
- R8: A start with `swapEn`=1 and a length that is not a multiple of 4 sets `error` at once. There is no power-up and no `progB` pulse.
- R9: After the last data bit (or at once, for a length of 0), `cclk` keeps pulsing. `doneIn` is checked after each pulse, and the run ends with `done`=1 after the first pulse that finds it high.
- R10: If `doneIn` is still low after DONE_PULSE_LIMIT pulses, the run ends with `error`=1.
- R11: A start pulse received while `busy` is 1 has no effect on the run in progress.
- R12: `done` and `error` are never both 1. Each stays set until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin configuration |
| swapEn | input | 1 | Reverse byte order within each 4-byte group |
| imageLen | input | LEN_W | Number of image bytes |
| halfPeriod | input | DIV_W | Configuration clock half-period in system clocks |
| inData | input | 8 | Image byte |
| inValid | input | 1 | `inData` holds a byte |
| inReady | output | 1 | Block accepts a byte this cycle |
| powerEn | output | 1 | Target power enable |
| progB | output | 1 | Target program line, active low |
| cclk | output | 1 | Configuration clock to target |
| din | output | 1 | Serial configuration data |
| initB | input | 1 | Target init line, high when ready |
| doneIn | input | 1 | Target done line |
| busy | output | 1 | Configuration in progress |
| done | output | 1 | Last run finished successfully (sticky) |
| error | output | 1 | Last run aborted (sticky) |

## Verification
The image is fed in several forms: an unswapped stream with gaps in the valid signal and a half-period of one, a swapped stream at a half-period of three, a zero-length image, and a stream interrupted by a stray start. Comparing the captured byte order separates the MSB-first shifting from the XOR-3 reordering. Measuring high and low run lengths of `cclk` shows whether the divider is honoured. Separate runs hold `initB` low, hold `doneIn` low, and give a misaligned swap length. Counting cycles and pulses in these runs pins each timeout to its exact limit, and shows that a misaligned request ends before any power-up.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PROG_LOW,
    ST_WAIT_INIT,
    ST_LOAD,
    ST_SHIFT,
    ST_FLUSH
  } loaderState_t;

  // strobes from control to the datapath
  typedef struct packed {
    logic       captureByte; // store inData into the group buffer
    logic [1:0] fillIdx;     // buffer slot for the captured byte
    logic       startGroup;  // begin draining a full group
    logic [1:0] groupLast;   // highest slot of a group (0 or 3)
    logic       runShift;    // clock data bits
    logic       startFlush;  // reset clock phase for trailing pulses
    logic       runFlush;    // clock trailing pulses
  } dpCtrl_t;

endpackage

// File: rtl/ssl_datapath.sv
module ssl_datapath
  import ssl_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [7:0]       inData,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             cclk,
  output logic             din,
  output logic             groupDone,
  output logic             pulseDone
);

  localparam int GROUP_BYTES = 4;

  logic [7:0]       byteBuf [GROUP_BYTES];
  logic [7:0]       shiftReg;
  logic [2:0]       bitCnt;
  logic [1:0]       drainIdx;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] effHalf;
  logic             cclkR;
  logic             running;
  logic             phaseEnd;
  logic             fallNow;

  assign effHalf  = (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
  assign phaseEnd = (divCnt == effHalf - DIV_W'(1));
  assign running  = ctl.runShift | ctl.runFlush;
  assign fallNow  = running & cclkR & phaseEnd;

  assign groupDone = ctl.runShift & fallNow & (bitCnt == 3'd7) & (drainIdx == 2'd0);
  assign pulseDone = ctl.runFlush & fallNow;

  assign cclk = cclkR;
  assign din  = shiftReg[7];

  for (genvar g = 0; g < GROUP_BYTES; g++) begin : gen_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        byteBuf[g] <= '0;
      else if (ctl.captureByte && ctl.fillIdx == 2'(g))
        byteBuf[g] <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      drainIdx <= '0;
      divCnt   <= '0;
      cclkR    <= 1'b0;
    end else if (ctl.startGroup) begin
      // the byte just captured is always the first one drained
      shiftReg <= inData;
      bitCnt   <= '0;
      drainIdx <= ctl.groupLast;
      divCnt   <= '0;
      cclkR    <= 1'b0;
    end else if (ctl.startFlush) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      cclkR    <= 1'b0;
    end else if (running) begin
      if (phaseEnd) begin
        divCnt <= '0;
        cclkR  <= ~cclkR;
        if (cclkR && ctl.runShift) begin
          if (bitCnt == 3'd7) begin
            bitCnt <= '0;
            if (drainIdx != 2'd0) begin
              drainIdx <= drainIdx - 2'd1;
              shiftReg <= byteBuf[drainIdx - 2'd1];
            end else begin
              shiftReg <= {shiftReg[6:0], 1'b0};
            end
          end else begin
            bitCnt   <= bitCnt + 3'd1;
            shiftReg <= {shiftReg[6:0], 1'b0};
          end
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
  import ssl_pkg::*;
#(
  parameter int LEN_W            = 16,
  parameter int SETTLE_CYCLES    = 5000000,
  parameter int PROG_LOW_CYCLES  = 5000000,
  parameter int INIT_POLL_LIMIT  = 100000,
  parameter int DONE_PULSE_LIMIT = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             swapEn,
  input  logic [LEN_W-1:0] imageLen,
  input  logic             inValid,
  input  logic             initB,
  input  logic             doneIn,
  input  logic             groupDone,
  input  logic             pulseDone,
  output dpCtrl_t          ctl,
  output logic             inReady,
  output logic             powerEn,
  output logic             progB,
  output logic             busy,
  output logic             done,
  output logic             error
);

  localparam int MAX_AB  = (SETTLE_CYCLES > PROG_LOW_CYCLES) ? SETTLE_CYCLES : PROG_LOW_CYCLES;
  localparam int MAX_CD  = (INIT_POLL_LIMIT > DONE_PULSE_LIMIT) ? INIT_POLL_LIMIT : DONE_PULSE_LIMIT;
  localparam int TMR_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  localparam logic [TMR_W-1:0] SETTLE_END = TMR_W'(SETTLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] PROG_END   = TMR_W'(PROG_LOW_CYCLES - 1);
  localparam logic [TMR_W-1:0] INIT_END   = TMR_W'(INIT_POLL_LIMIT - 1);
  localparam logic [TMR_W-1:0] DONE_END   = TMR_W'(DONE_PULSE_LIMIT - 1);

  loaderState_t     state;
  logic [TMR_W-1:0] timer;
  logic [LEN_W-1:0] remaining;
  logic [1:0]       fillIdx;
  logic             swapR;
  logic             doneR, errR, powerR, progR;
  logic             lastInGroup;
  logic             misaligned;

  assign misaligned  = swapEn & (imageLen[1:0] != 2'b00);
  assign lastInGroup = (fillIdx == ctl.groupLast);

  always_comb begin
    ctl             = '0;
    ctl.fillIdx     = fillIdx;
    ctl.groupLast   = swapR ? 2'd3 : 2'd0;
    ctl.captureByte = (state == ST_LOAD) && inValid;
    ctl.startGroup  = ctl.captureByte && lastInGroup;
    ctl.runShift    = (state == ST_SHIFT);
    ctl.runFlush    = (state == ST_FLUSH);
    ctl.startFlush  = ((state == ST_WAIT_INIT) && initB && remaining == '0) ||
                      ((state == ST_SHIFT) && groupDone && remaining == '0);
  end

  assign inReady = (state == ST_LOAD);
  assign busy    = (state != ST_IDLE);
  assign done    = doneR;
  assign error   = errR;
  assign powerEn = powerR;
  assign progB   = progR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      remaining <= '0;
      fillIdx   <= '0;
      swapR     <= 1'b0;
      doneR     <= 1'b0;
      errR      <= 1'b0;
      powerR    <= 1'b0;
      progR     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            doneR <= 1'b0;
            if (misaligned) begin
              errR <= 1'b1;
            end else begin
              errR      <= 1'b0;
              powerR    <= 1'b1;
              swapR     <= swapEn;
              remaining <= imageLen;
              fillIdx   <= '0;
              timer     <= '0;
              state     <= ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (timer == SETTLE_END) begin
            timer <= '0;
            progR <= 1'b0;
            state <= ST_PROG_LOW;
          end else begin
            timer <= timer + TMR_W'(1);
          end
        end
        ST_PROG_LOW: begin
          if (timer == PROG_END) begin
            timer <= '0;
            progR <= 1'b1;
            state <= ST_WAIT_INIT;
          end else begin
            timer <= timer + TMR_W'(1);
          end
        end
        ST_WAIT_INIT: begin
          if (initB) begin
            timer <= '0;
            state <= (remaining == '0) ? ST_FLUSH : ST_LOAD;
          end else if (timer == INIT_END) begin
            errR  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            timer <= timer + TMR_W'(1);
          end
        end
        ST_LOAD: begin
          if (ctl.captureByte) begin
            remaining <= remaining - LEN_W'(1);
            if (lastInGroup) begin
              fillIdx <= '0;
              state   <= ST_SHIFT;
            end else begin
              fillIdx <= fillIdx + 2'd1;
            end
          end
        end
        ST_SHIFT: begin
          if (groupDone) begin
            timer <= '0;
            state <= (remaining == '0) ? ST_FLUSH : ST_LOAD;
          end
        end
        ST_FLUSH: begin
          if (pulseDone) begin
            if (doneIn) begin
              doneR <= 1'b1;
              state <= ST_IDLE;
            end else if (timer == DONE_END) begin
              errR  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              timer <= timer + TMR_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/slave_serial_loader.sv
module slave_serial_loader
  import ssl_pkg::*;
#(
  parameter int LEN_W            = 16,
  parameter int DIV_W            = 4,
  parameter int SETTLE_CYCLES    = 5000000,
  parameter int PROG_LOW_CYCLES  = 5000000,
  parameter int INIT_POLL_LIMIT  = 100000,
  parameter int DONE_PULSE_LIMIT = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             swapEn,
  input  logic [LEN_W-1:0] imageLen,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             powerEn,
  output logic             progB,
  output logic             cclk,
  output logic             din,
  input  logic             initB,
  input  logic             doneIn,
  output logic             busy,
  output logic             done,
  output logic             error
);

  dpCtrl_t ctl;
  logic    groupDone;
  logic    pulseDone;

  ssl_ctrl #(
    .LEN_W           (LEN_W),
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .PROG_LOW_CYCLES (PROG_LOW_CYCLES),
    .INIT_POLL_LIMIT (INIT_POLL_LIMIT),
    .DONE_PULSE_LIMIT(DONE_PULSE_LIMIT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .swapEn   (swapEn),
    .imageLen (imageLen),
    .inValid  (inValid),
    .initB    (initB),
    .doneIn   (doneIn),
    .groupDone(groupDone),
    .pulseDone(pulseDone),
    .ctl      (ctl),
    .inReady  (inReady),
    .powerEn  (powerEn),
    .progB    (progB),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  ssl_datapath #(
    .DIV_W(DIV_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inData    (inData),
    .halfPeriod(halfPeriod),
    .cclk      (cclk),
    .din       (din),
    .groupDone (groupDone),
    .pulseDone (pulseDone)
  );

endmodule

// File: rtl/ssl_checker.sv
module ssl_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic error,
  input logic powerEn,
  input logic progB,
  input logic cclk,
  input logic din,
  input logic inReady
);

  assert_power_gates_pins_R2: assert property (@(posedge clk) disable iff (!rstN)
    !powerEn |-> (!cclk && progB));

  assert_prog_released_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> progB);

  assert_din_steady_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cclk && $past(cclk)) |-> $stable(din));

  assert_clock_low_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !cclk);

  assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_error_cleared_by_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(error) |-> $past(start));

  assert_done_cleared_by_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(start));

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

bind slave_serial_loader ssl_checker chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .error  (error),
  .powerEn(powerEn),
  .progB  (progB),
  .cclk   (cclk),
  .din    (din),
  .inReady(inReady)
);

// File: tb/slave_serial_loader_tb_top.sv
module slave_serial_loader_tb_top;

  localparam int S    = 20;
  localparam int P    = 15;
  localparam int L    = 30;
  localparam int DL   = 10;
  localparam int LENW = 12;
  localparam int DIVW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0, swapEn = 1'b0;
  logic [LENW-1:0] imageLen = '0;
  logic [DIVW-1:0] halfPeriod = 4'd1;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, initB = 1'b1, doneIn = 1'b0;
  logic inReady, powerEn, progB, cclk, din, busy, done, error;

  slave_serial_loader #(
    .LEN_W(LENW), .DIV_W(DIVW), .SETTLE_CYCLES(S), .PROG_LOW_CYCLES(P),
    .INIT_POLL_LIMIT(L), .DONE_PULSE_LIMIT(DL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .swapEn(swapEn), .imageLen(imageLen),
    .halfPeriod(halfPeriod), .inData(inData), .inValid(inValid), .inReady(inReady),
    .powerEn(powerEn), .progB(progB), .cclk(cclk), .din(din), .initB(initB),
    .doneIn(doneIn), .busy(busy), .done(done), .error(error)
  );

  int checks = 0, errors = 0;

  // run configuration for the target model
  int curLen = 0, curSwap = 0, curHp = 1, initDelay = 0, doneAfter = -1, seed = 0;
  // observations
  int settleCnt, progLowCnt, pollCnt, flushRises, capBitCnt, highBad, lowBad, dinBad;
  int srcIdx, initTimer, highRun, lowRun, cyc = 0;
  bit seenLow, prevCclk, prevDin, xferPending;
  logic [7:0] capBytes [64];
  bit firstBusy, firstDone, firstErr;

  function automatic logic [7:0] imgByte(int i);
    return 8'((i * 29 + seed * 7 + 3) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    settleCnt = 0; progLowCnt = 0; pollCnt = 0; flushRises = 0; capBitCnt = 0;
    highBad = 0; lowBad = 0; dinBad = 0; srcIdx = 0; initTimer = 0;
    highRun = 0; lowRun = 0; seenLow = 0; xferPending = 0;
    for (int i = 0; i < 64; i++) capBytes[i] = '0;
  endtask

  // behavioural model of the target and the byte source, sampled away from the edge
  initial begin : target_model
    clearMon();
    forever begin
      @(negedge clk);
      cyc++;
      if (xferPending) srcIdx++;
      if (busy && !seenLow && progB) settleCnt++;
      if (!progB) begin
        seenLow = 1; progLowCnt++; initB = 1'b0; initTimer = 0;
      end else if (seenLow) begin
        if (busy && initDelay < 0) pollCnt++;
        if (initDelay >= 0 && !initB) begin
          if (initTimer >= initDelay) initB = 1'b1;
          else initTimer++;
        end
      end
      if (cclk && !prevCclk) begin
        if (lowRun < curHp) lowBad++;
        highRun = 1;
        if (capBitCnt < 8 * curLen) begin
          capBytes[capBitCnt / 8] = {capBytes[capBitCnt / 8][6:0], din};
          capBitCnt++;
        end else begin
          flushRises++;
          if (flushRises == doneAfter) doneIn = 1'b1;
        end
      end else if (cclk) begin
        highRun++;
        if (din !== prevDin) dinBad++;
      end else begin
        if (prevCclk && highRun != curHp) highBad++;
        if (prevCclk) lowRun = 1; else lowRun++;
      end
      prevCclk = cclk;
      prevDin  = din;
      inValid  = (srcIdx < curLen) && (cyc % 5 != 3);
      inData   = inValid ? imgByte(srcIdx) : 8'h00;
      xferPending = inValid && inReady;
    end
  end

  task automatic runCase(int len, int swap, int hp, int idly, int dafter, int sd, bit poke);
    int n;
    @(posedge clk); #1;
    curLen = len; curSwap = swap; curHp = (hp == 0) ? 1 : hp;
    initDelay = idly; doneAfter = dafter; seed = sd;
    clearMon();
    doneIn = 1'b0; initB = 1'b1;
    swapEn = swap[0]; imageLen = LENW'(len); halfPeriod = DIVW'(hp);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk); #1;
    firstBusy = busy; firstDone = done; firstErr = error;
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk); #1;
      n++;
      if (poke && n == S + P + 12) begin
        start = 1'b1; swapEn = 1'b1; imageLen = LENW'(5);
      end else if (poke && n == S + P + 13) begin
        start = 1'b0; swapEn = swap[0]; imageLen = LENW'(len);
      end
    end
  endtask

  task automatic checkBytes(string req);
    int bad = 0, firstK = -1;
    for (int k = 0; k < curLen; k++) begin
      int src = curSwap ? (k ^ 3) : k;
      if (capBytes[k] !== imgByte(src)) begin
        bad++;
        if (firstK < 0) firstK = k;
      end
    end
    check(capBitCnt == 8 * curLen, req, "data bit count", capBitCnt, 8 * curLen);
    check(bad == 0, req, "byte mismatch (first index shown as actual)", firstK, -1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset state
    check(!busy && !done && !error, "R1", "flags at reset", {busy, done, error}, 0);
    check(progB && !cclk && !din && !powerEn && !inReady, "R1", "pins at reset",
          {progB, cclk, din, powerEn, inReady}, 5'b10000);
    @(posedge clk); #1 rstN = 1'b1;

    // plain stream with gaps, half-period 1
    runCase(6, 0, 1, 5, 3, 1, 0);
    check(settleCnt == S, "R2", "settle cycles", settleCnt, S);
    check(powerEn == 1'b1, "R2", "power enable held", powerEn, 1);
    check(progLowCnt == P, "R3", "program low cycles", progLowCnt, P);
    checkBytes("R5");
    check(dinBad == 0, "R5", "din changes while cclk high", dinBad, 0);
    check(highBad == 0 && lowBad == 0, "R6", "run length faults hp1", highBad + lowBad, 0);
    check(flushRises == 3, "R9", "trailing pulses", flushRises, 3);
    check(done && !error && !busy, "R9", "done flags", {done, error, busy}, 3'b100);
    repeat (40) @(negedge clk);
    #1 check(done && !error, "R12", "done sticky", {done, error}, 2'b10);

    // swapped stream, half-period 3
    runCase(8, 1, 3, 0, 1, 2, 0);
    check(firstBusy && !firstDone && !firstErr, "R12", "start clears done",
          {firstBusy, firstDone, firstErr}, 3'b100);
    checkBytes("R7");
    check(highBad == 0 && lowBad == 0, "R6", "run length faults hp3", highBad + lowBad, 0);
    check(flushRises == 1 && done, "R9", "single trailing pulse", flushRises, 1);

    // half-period 0 behaves as 1
    runCase(2, 0, 0, 2, 2, 3, 0);
    check(highBad == 0 && lowBad == 0 && done, "R6", "zero divider", highBad + lowBad, 0);

    // misaligned swap request
    runCase(5, 1, 1, 0, 1, 4, 0);
    check(error && !busy && !done, "R8", "misaligned error", {error, busy, done}, 3'b100);
    check(progLowCnt == 0 && settleCnt == 0, "R8", "no program pulse", progLowCnt, 0);
    repeat (30) @(negedge clk);
    #1 check(error && !done, "R12", "error sticky", {error, done}, 2'b10);

    // init never rises
    runCase(4, 0, 1, -1, 1, 5, 0);
    check(firstBusy && !firstErr, "R12", "start clears error", {firstBusy, firstErr}, 2'b10);
    check(pollCnt == L, "R4", "init poll count", pollCnt, L);
    check(error && !busy && capBitCnt == 0, "R4", "init timeout", {error, busy}, 2'b10);

    // done never rises
    runCase(2, 0, 2, 1, -1, 6, 0);
    check(flushRises == DL, "R10", "pulses before timeout", flushRises, DL);
    check(error && !done && !busy, "R10", "done timeout flags", {error, done, busy}, 3'b100);

    // zero length goes straight to trailing pulses
    runCase(0, 0, 1, 1, 2, 7, 0);
    check(capBitCnt == 0 && flushRises == 2 && done, "R9", "zero length", flushRises, 2);

    // stray misaligned start while busy
    runCase(8, 0, 1, 1, 2, 8, 1);
    check(done && !error, "R11", "stray start ignored", {done, error}, 2'b10);
    checkBytes("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule